// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is an up-counter built from identical narrow stages (four bits each by default) that all switch on the same rising clock edge. Each stage can be preset from a parallel input, cleared at once by an active-low clear, and advanced under two count enables. One enable, the "pass" enable, gates counting alone. The other, the "chain" enable, also gates the stage's terminal-count carry.

The top module chains the stages into one wide counter, twelve bits by default. The pass enable, clock, clear and load are shared by every stage. The chain enable of the lowest stage comes from the port. Each higher stage takes its chain enable from the carry of the stage below it. No stage is clocked by another stage, so every bit of the wide count changes on the same edge. The carry of the top stage is a port, so a further counter can extend the chain.

Priority, from highest to lowest: asynchronous clear, synchronous load, counting, hold.

Top module: `cascade_counter`

## Requirements
- R1: While `clr_n` is low, `count` is 0 without waiting for a clock edge, whatever the clock, `ld_n`, `en_pass` and `en_chain` are doing.
- R2: With `clr_n` high and `ld_n` low at a rising edge, `count` takes `preset` at that edge, whatever the levels of `en_pass` and `en_chain`.
- R3: With `clr_n` and `ld_n` high and both `en_pass` and `en_chain` high at a rising edge, `count` increases by one.
- R4: With `clr_n` and `ld_n` high and either enable low at a rising edge, `count` keeps its value.
- R5: Counting wraps from all ones (0xFFF at the default width) to 0.
- R6: `carry_out` is high exactly when `count` is all ones and `en_chain` is high. It is combinational, so a change on `en_chain` shows on `carry_out` without a clock edge.
- R7: Across every stage boundary (for example 0x00F to 0x010 and 0x0FF to 0x100), the chained counter advances by exactly one per enabled edge.
- R8: Changes on `ld_n`, `en_pass` or `en_chain` between rising edges leave `count` unchanged until the next rising edge.
- R9: Clear overrides a pending load. A clear asserted in mid-cycle while `ld_n` is low and both enables are high leaves `count` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel load, active low |
| preset | input | STAGE_W*N_STAGES | Value taken on a load |
| en_pass | input | 1 | Count enable that does not gate the carry |
| en_chain | input | 1 | Count enable that also gates the carry |
| count | output | STAGE_W*N_STAGES | Current count |
| carry_out | output | 1 | High when the count is all ones and en_chain is high |

## Verification
The hardest conditions to reach from the ports are the carry crossing a stage boundary and the wrap of the full width. Reaching them by plain counting would take thousands of cycles. The stimulus instead presets the counter just below 0x00F, 0x0FF and 0xFFF, then counts through each boundary, checking count and carry after every edge. A second hard condition is an asynchronous clear that arrives in mid-cycle while a load is pending. The bench drops the clear between edges and reads the count before any edge can occur. It also toggles the chain enable with the count held at all ones, to see the carry follow it without a clock.

// File: rtl/cascade_cnt_pkg.sv
`timescale 1ns/1ps
package cascade_cnt_pkg;
  // Action a stage takes at the next rising edge.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } stage_op_e;

  // Choose the stage action from the control inputs.
  function automatic stage_op_e pick_op(input logic ld_n, input logic en_a, input logic en_b);
    if (!ld_n)            return OP_LOAD;
    else if (en_a && en_b) return OP_COUNT;
    else                  return OP_HOLD;
  endfunction
endpackage

// File: rtl/cnt_stage_ctl.sv
`timescale 1ns/1ps
module cnt_stage_ctl
  import cascade_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             ld_n,
  input  logic             en_pass,
  input  logic             en_chain,
  input  logic [WIDTH-1:0] q_cur,
  input  logic [WIDTH-1:0] din,
  output stage_op_e        op,
  output logic [WIDTH-1:0] q_nxt,
  output logic             carry
);
  localparam logic [WIDTH-1:0] TOP_VAL = {WIDTH{1'b1}};

  always_comb begin
    op = pick_op(ld_n, en_pass, en_chain);
    unique case (op)
      OP_LOAD:  q_nxt = din;
      OP_COUNT: q_nxt = q_cur + 1'b1;
      default:  q_nxt = q_cur;
    endcase
  end

  // Terminal count, qualified by the chain enable only.
  assign carry = en_chain && (q_cur == TOP_VAL);
endmodule

// File: rtl/cnt_stage.sv
`timescale 1ns/1ps
module cnt_stage
  import cascade_cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic             en_pass,
  input  logic             en_chain,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             carry
);
  stage_op_e        op;
  logic [WIDTH-1:0] q_nxt;
  logic             upd_en;

  cnt_stage_ctl #(.WIDTH(WIDTH)) u_ctl (
    .ld_n     (ld_n),
    .en_pass  (en_pass),
    .en_chain (en_chain),
    .q_cur    (q),
    .din      (din),
    .op       (op),
    .q_nxt    (q_nxt),
    .carry    (carry)
  );

  assign upd_en = (op != OP_HOLD);

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)      q <= '0;
    else if (upd_en) q <= q_nxt;
  end

  // R1: cleared state observed at any edge while clear is held
  always @(posedge clk) begin
    if (!clr_n) p_clear_zero_r1: assert (q == '0);
  end

  p_load_takes_din_r2: assert property (@(posedge clk) disable iff (!clr_n)
    !ld_n |=> q == $past(din));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_pass && en_chain) |=> q == $past(q) + 1'b1);

  p_hold_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && !(en_pass && en_chain)) |=> $stable(q));
endmodule

// File: rtl/cascade_counter.sv
`timescale 1ns/1ps
module cascade_counter #(
  parameter int STAGE_W  = 4,
  parameter int N_STAGES = 3,
  localparam int TOTAL_W = STAGE_W * N_STAGES
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               ld_n,
  input  logic [TOTAL_W-1:0] preset,
  input  logic               en_pass,
  input  logic               en_chain,
  output logic [TOTAL_W-1:0] count,
  output logic               carry_out
);
  logic [N_STAGES:0]   chain;
  logic [N_STAGES-1:0] stage_carry;

  assign chain[0] = en_chain;

  for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
    cnt_stage #(.WIDTH(STAGE_W)) u_stage (
      .clk      (clk),
      .clr_n    (clr_n),
      .ld_n     (ld_n),
      .en_pass  (en_pass),
      .en_chain (chain[s]),
      .din      (preset[s*STAGE_W +: STAGE_W]),
      .q        (count[s*STAGE_W +: STAGE_W]),
      .carry    (stage_carry[s])
    );
    assign chain[s+1] = stage_carry[s];
  end

  assign carry_out = chain[N_STAGES];

  // R6: carry seen at the top only with the whole count at all ones
  p_carry_full_r6: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (&count && en_chain));

  // R7: the chained value moves by exactly one per enabled edge
  p_wide_step_r7: assert property (@(posedge clk) disable iff (!clr_n)
    (ld_n && en_pass && en_chain) |=> count == $past(count) + 1'b1);
endmodule

// File: tb/cascade_counter_test.sv
`timescale 1ns/1ps
module cascade_counter_test;
  localparam int SW = 4;
  localparam int NS = 3;
  localparam int W  = SW * NS;
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic         clk = 1'b0;
  logic         clr_n, ld_n, en_pass, en_chain;
  logic [W-1:0] preset;
  logic [W-1:0] count;
  logic         carry_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] mdl;
  logic [W:0]   exp_q[$];
  string        req_q[$];

  always #4 clk = ~clk;

  cascade_counter #(.STAGE_W(SW), .N_STAGES(NS)) uut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .preset(preset),
    .en_pass(en_pass), .en_chain(en_chain),
    .count(count), .carry_out(carry_out)
  );

  task automatic check(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: carry/count got %h expected %h", req, act, exp);
    end
  endtask

  // Driver: apply one cycle of inputs, update the model, push the expectation.
  task automatic step(input logic ld, input logic p, input logic t,
                      input logic [W-1:0] d, input string req);
    @(negedge clk);
    ld_n = ld; en_pass = p; en_chain = t; preset = d;
    @(posedge clk);
    if (!ld)        mdl = d;
    else if (p && t) mdl = mdl + 1'b1;
    exp_q.push_back({t && (mdl == ALL1), mdl});
    req_q.push_back(req);
  endtask

  // Monitor: compare each edge's result once the outputs settle.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        automatic logic [W:0] e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        check({carry_out, count} === e, r, {carry_out, count}, e);
      end
    end
  end

  initial begin
    #(200000 * 8);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    clr_n = 1'b1; ld_n = 1'b1; en_pass = 1'b0; en_chain = 1'b0; preset = '0;
    #1 clr_n = 1'b0;
    #1 check(count === '0, "R1", {carry_out, count}, '0);
    mdl = '0;
    @(negedge clk); #3 clr_n = 1'b1;

    // Reference sequence at the top of the range: preset, count through wrap, hold
    step(1'b0, 1'b0, 1'b0, 12'hFFC, "R2");
    step(1'b1, 1'b1, 1'b1, '0, "R3");
    step(1'b1, 1'b1, 1'b1, '0, "R3");
    step(1'b1, 1'b1, 1'b1, '0, "R6");   // reaches all ones, carry high
    step(1'b1, 1'b1, 1'b1, '0, "R5");   // wrap to 0
    step(1'b1, 1'b1, 1'b1, '0, "R3");
    step(1'b1, 1'b1, 1'b1, '0, "R3");
    step(1'b1, 1'b0, 1'b0, '0, "R4");
    step(1'b1, 1'b0, 1'b1, '0, "R4");
    step(1'b1, 1'b1, 1'b0, '0, "R4");

    // Load with enables mixed
    step(1'b0, 1'b1, 1'b1, 12'h00E, "R2");
    step(1'b1, 1'b1, 1'b1, '0, "R7");   // 0x00F
    step(1'b1, 1'b1, 1'b1, '0, "R7");   // 0x010
    step(1'b0, 1'b0, 1'b1, 12'h0FE, "R2");
    step(1'b1, 1'b1, 1'b1, '0, "R7");   // 0x0FF
    step(1'b1, 1'b1, 1'b1, '0, "R7");   // 0x100

    // Hold at all ones: carry follows en_chain with no edge (R6)
    step(1'b0, 1'b0, 1'b0, ALL1, "R2");
    step(1'b1, 1'b0, 1'b1, '0, "R6");
    @(negedge clk);
    en_chain = 1'b0; #1;
    check(carry_out === 1'b0, "R6", {carry_out, count}, {1'b0, ALL1});
    en_chain = 1'b1; #1;
    check(carry_out === 1'b1, "R6", {carry_out, count}, {1'b1, ALL1});

    // Mid-cycle control changes do not touch the count (R8)
    step(1'b0, 1'b0, 1'b0, 12'h3A5, "R2");
    @(negedge clk);
    ld_n = 1'b0; preset = 12'h111; en_pass = 1'b1; en_chain = 1'b1; #1;
    ld_n = 1'b1; en_pass = 1'b0; #1;
    check({carry_out, count} === {1'b0, 12'h3A5}, "R8", {carry_out, count}, {1'b0, 12'h3A5});

    // Long run across many boundaries
    step(1'b0, 1'b0, 1'b0, 12'h0F0, "R2");
    for (int i = 0; i < 300; i++) step(1'b1, 1'b1, 1'b1, '0, "R7");

    // Mid-cycle clear with a load pending and enables high (R1, R9)
    @(negedge clk);
    ld_n = 1'b0; preset = 12'hABC; en_pass = 1'b1; en_chain = 1'b1;
    #1 clr_n = 1'b0;
    #1 check({carry_out, count} === '0, "R9", {carry_out, count}, '0);
    @(posedge clk); #2;
    check({carry_out, count} === '0, "R1", {carry_out, count}, '0);
    mdl = '0;
    @(negedge clk); ld_n = 1'b1; en_pass = 1'b0; #3 clr_n = 1'b1;
    step(1'b1, 1'b1, 1'b1, '0, "R3");

    @(posedge clk); #3;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule